// File: doc/BRIEF.md
# Serial Flash Opcode Dispatcher

This block sits after a serial-peripheral slave byte deserializer. It inspects the first byte received in a chip-select window. It compares that byte against a run-time programmable table of command slots. Each slot carries a valid bit, an opcode byte, a read-command attribute, an upload attribute and a two-bit read pipeline mode. When a command is recognised, the block registers the winning slot's opcode and pipeline mode. It moves a one-hot state machine to the handler state for that command class and raises one bit of a one-hot datapath select. It then holds that decision until chip select is released.

The dispatch depends on three things: the operating mode, a busy status bit, and three intercept enables that apply in passthrough mode. In flash mode, status, identification and discovery-table commands always go to their local handlers. In passthrough mode they go there only when their intercept is enabled. Otherwise the machine parks in the wait state, so that forwarding logic outside this block can handle the command. Address-mode and write-enable changes are refused while busy. An upload slot is also refused while busy.

Top module: `flash_cmd_dispatch`

## Requirements
- R1: After reset, state_o is 9'h001 (idle), dp_sel_o is 0, lat_opcode_o, lat_pipe_o and two_stage_o are 0.
- R2: A slot matches only when its valid bit is 1 and its opcode equals byte_i. A decoded byte that matches no slot moves the machine to wait (state_o = 9'h100) with dp_sel_o = 0.
- R3: A byte is decoded only when the machine is idle, csb_i is low, byte_valid_i is 1 and mode_i is 0 (flash) or 1 (passthrough). With mode_i = 2 or 3 the machine stays idle. Bytes that arrive after the first decode change neither the state, the select nor the latched information.
- R4: A match on any of slots 0..NSTATUS-1 (default 0, 1, 2) is a status command: state_o = 9'h002 and dp_sel_o bit 0.
- R5: A match on slot 3 is an identification read: state_o = 9'h004 and dp_sel_o bit 1. A match on slot 4 is a discovery-table read: state_o = 9'h008 and dp_sel_o bit 2.
- R6: In passthrough mode, the commands of R4 and R5 enter their handler only when their intercept is enabled: icpt_status_i, icpt_jedec_i and icpt_sfdp_i respectively. Otherwise the machine enters wait with dp_sel_o = 0. Flash mode ignores the intercepts.
- R7: Slot 5 (enter 4-byte address) and slot 6 (exit 4-byte address) both enter state_o = 9'h040, with dp_sel_o bit 5 or bit 6 respectively. Slot 7 (write enable) and slot 8 (write disable) both enter state_o = 9'h080, with dp_sel_o bit 7 or bit 8.
- R8: While busy_i is 1, the slot 5..8 matches are suppressed and the upload attribute is not honoured. Such a byte enters wait with dp_sel_o = 0.
- R9: For any other match, the winning slot's attributes decide the result. With the read-command attribute set, the machine enters state_o = 9'h010 with dp_sel_o bit 3; this takes precedence over upload. With only the upload attribute set, it enters state_o = 9'h020 with dp_sel_o bit 4. With neither attribute set, it enters wait with dp_sel_o = 0.
- R10: When several slots match, the lowest-index slot wins, both for dispatch and for the latched information.
- R11: On a match, lat_opcode_o and lat_pipe_o take the winning slot's opcode and pipeline mode in the next cycle. two_stage_o is 1 exactly when the latched pipeline mode is 2 (two-stage half cycle) or 3 (two-stage full cycle). The values hold until the next match.
- R12: While csb_i is high, the next cycle shows the idle state with dp_sel_o = 0, whatever byte is presented.
- R13: state_o is always one-hot and dp_sel_o has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csb_i | input | 1 | Chip select, active low; high returns to idle |
| byte_i | input | OPW | Received byte |
| byte_valid_i | input | 1 | byte_i holds a new byte this cycle |
| mode_i | input | 2 | 0 flash, 1 passthrough, 2/3 inactive |
| busy_i | input | 1 | Device busy status |
| icpt_status_i | input | 1 | Passthrough intercept for status commands |
| icpt_jedec_i | input | 1 | Passthrough intercept for identification read |
| icpt_sfdp_i | input | 1 | Passthrough intercept for discovery-table read |
| slot_valid_i | input | NSLOT | Per-slot valid bits |
| slot_opcode_i | input | NSLOT*OPW | Per-slot opcodes, slot i at bits i*OPW |
| slot_rdcmd_i | input | NSLOT | Per-slot read-command attribute |
| slot_upload_i | input | NSLOT | Per-slot upload attribute |
| slot_pipe_i | input | NSLOT*PIPEW | Per-slot read pipeline mode, slot i at bits i*PIPEW |
| state_o | output | 9 | One-hot state |
| dp_sel_o | output | 9 | One-hot datapath select, 0 = none |
| lat_opcode_o | output | OPW | Latched opcode of winning slot |
| lat_pipe_o | output | PIPEW | Latched pipeline mode |
| two_stage_o | output | 1 | Latched pipeline mode is a two-stage mode |

## Verification
The bench sweeps every slot opcode, one unmatched byte, all four mode codes, both busy values and all eight intercept combinations. It compares the state and select against a model built from the requirements.

Several corner cases get specific attention. An invalid slot whose opcode matches must fall to wait; a design that ignored the valid bit would enter that slot's handler. A slot with both attributes must pick the read path; reversed precedence would select upload. Two slots sharing an opcode must latch the lower slot's pipeline mode; a design with the wrong priority would report the other mode and the wrong two-stage flag. A second byte after entry must leave the state alone; a design that re-decoded would jump to the identification handler. A byte shown while chip select is high must not be decoded; a design that let it through would leave idle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   localparam int unsigned ST_N = 9;
   localparam int unsigned DP_N = 9;

   typedef enum logic [ST_N-1:0] {
      ST_IDLE   = 9'h001,
      ST_STATUS = 9'h002,
      ST_JEDEC  = 9'h004,
      ST_SFDP   = 9'h008,
      ST_READ   = 9'h010,
      ST_UPLOAD = 9'h020,
      ST_ADDR   = 9'h040,
      ST_WRMODE = 9'h080,
      ST_WAIT   = 9'h100
   } fcd_state_e;

   // bit positions in the datapath select
   localparam int unsigned DP_STATUS = 0;
   localparam int unsigned DP_JEDEC  = 1;
   localparam int unsigned DP_SFDP   = 2;
   localparam int unsigned DP_READ   = 3;
   localparam int unsigned DP_UPLOAD = 4;
   localparam int unsigned DP_EN4B   = 5;
   localparam int unsigned DP_EX4B   = 6;
   localparam int unsigned DP_WREN   = 7;
   localparam int unsigned DP_WRDI   = 8;

   localparam logic [1:0] MODE_FLASH = 2'd0;
   localparam logic [1:0] MODE_PASS  = 2'd1;

   localparam int unsigned PIPE_HALF = 2;
   localparam int unsigned PIPE_FULL = 3;

   // fixed slots following the status group
   localparam int unsigned OFS_JEDEC = 0;
   localparam int unsigned OFS_SFDP  = 1;
   localparam int unsigned OFS_EN4B  = 2;
   localparam int unsigned OFS_EX4B  = 3;
   localparam int unsigned OFS_WREN  = 4;
   localparam int unsigned OFS_WRDI  = 5;
   localparam int unsigned N_FIXED   = 6;

endpackage

// File: rtl/fcd_slot_match.sv
module fcd_slot_match #(
   parameter int unsigned NSLOT = 24,
   parameter int unsigned OPW   = 8,
   localparam int unsigned IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic [NSLOT-1:0]     slot_valid_i,
   input  logic [NSLOT*OPW-1:0] slot_opcode_i,
   input  logic [OPW-1:0]       byte_i,
   output logic [NSLOT-1:0]     hit_o,
   output logic [IDXW-1:0]      win_idx_o
);

   for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
      assign hit_o[g] = slot_valid_i[g] && (slot_opcode_i[g*OPW +: OPW] == byte_i);
   end

   // lowest index wins: scan downwards so the last assignment is the lowest hit
   always_comb begin
      win_idx_o = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (hit_o[i]) win_idx_o = IDXW'(i);
      end
   end

endmodule

// File: rtl/fcd_classify.sv
module fcd_classify
   import fcd_pkg::*;
#(
   parameter int unsigned NSLOT   = 24,
   parameter int unsigned NSTATUS = 3
) (
   input  logic [NSLOT-1:0] hit_i,
   input  logic             win_rdcmd_i,
   input  logic             win_upload_i,
   input  logic             pass_i,
   input  logic             busy_i,
   input  logic             icpt_status_i,
   input  logic             icpt_jedec_i,
   input  logic             icpt_sfdp_i,
   output logic             any_hit_o,
   output fcd_state_e       nxt_state_o,
   output logic [DP_N-1:0]  nxt_dp_o
);

   localparam int unsigned I_JEDEC = NSTATUS + OFS_JEDEC;
   localparam int unsigned I_SFDP  = NSTATUS + OFS_SFDP;
   localparam int unsigned I_EN4B  = NSTATUS + OFS_EN4B;
   localparam int unsigned I_EX4B  = NSTATUS + OFS_EX4B;
   localparam int unsigned I_WREN  = NSTATUS + OFS_WREN;
   localparam int unsigned I_WRDI  = NSTATUS + OFS_WRDI;

   logic stat_hit;
   logic addr_hit;
   logic wr_hit;

   assign any_hit_o = |hit_i;
   assign stat_hit  = |hit_i[NSTATUS-1:0];
   assign addr_hit  = !busy_i && (hit_i[I_EN4B] || hit_i[I_EX4B]);
   assign wr_hit    = !busy_i && (hit_i[I_WREN] || hit_i[I_WRDI]);

   always_comb begin
      nxt_state_o = ST_WAIT;
      nxt_dp_o    = '0;
      if (any_hit_o) begin
         if (stat_hit) begin
            if (!pass_i || icpt_status_i) begin
               nxt_state_o         = ST_STATUS;
               nxt_dp_o[DP_STATUS] = 1'b1;
            end
         end else if (hit_i[I_JEDEC]) begin
            if (!pass_i || icpt_jedec_i) begin
               nxt_state_o        = ST_JEDEC;
               nxt_dp_o[DP_JEDEC] = 1'b1;
            end
         end else if (hit_i[I_SFDP]) begin
            if (!pass_i || icpt_sfdp_i) begin
               nxt_state_o       = ST_SFDP;
               nxt_dp_o[DP_SFDP] = 1'b1;
            end
         end else if (win_rdcmd_i) begin
            nxt_state_o       = ST_READ;
            nxt_dp_o[DP_READ] = 1'b1;
         end else if (win_upload_i && !busy_i) begin
            nxt_state_o         = ST_UPLOAD;
            nxt_dp_o[DP_UPLOAD] = 1'b1;
         end else if (addr_hit) begin
            nxt_state_o = ST_ADDR;
            if (hit_i[I_EN4B]) nxt_dp_o[DP_EN4B] = 1'b1;
            else               nxt_dp_o[DP_EX4B] = 1'b1;
         end else if (wr_hit) begin
            nxt_state_o = ST_WRMODE;
            if (hit_i[I_WREN]) nxt_dp_o[DP_WREN] = 1'b1;
            else               nxt_dp_o[DP_WRDI] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fcd_info_latch.sv
module fcd_info_latch
   import fcd_pkg::*;
#(
   parameter int unsigned OPW           = 8,
   parameter int unsigned PIPEW         = 2,
   parameter bit          TWO_STAGE_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [OPW-1:0]   opcode_i,
   input  logic [PIPEW-1:0] pipe_i,
   output logic [OPW-1:0]   opcode_o,
   output logic [PIPEW-1:0] pipe_o,
   output logic             two_stage_o
);

   function automatic logic is_two_stage(input logic [PIPEW-1:0] p);
      return (p == PIPEW'(PIPE_HALF)) || (p == PIPEW'(PIPE_FULL));
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         opcode_o <= '0;
         pipe_o   <= '0;
      end else if (load_i) begin
         opcode_o <= opcode_i;
         pipe_o   <= pipe_i;
      end
   end

   if (TWO_STAGE_REG) begin : g_flag_reg
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     flag_q <= 1'b0;
         else if (load_i) flag_q <= is_two_stage(pipe_i);
      end
      assign two_stage_o = flag_q;
   end else begin : g_flag_comb
      assign two_stage_o = is_two_stage(pipe_o);
   end

   a_r11_hold_without_load : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(opcode_o) && $stable(pipe_o) && $stable(two_stage_o));

endmodule

// File: rtl/flash_cmd_dispatch.sv
module flash_cmd_dispatch
   import fcd_pkg::*;
#(
   parameter int unsigned NSLOT         = 24,
   parameter int unsigned NSTATUS       = 3,
   parameter int unsigned OPW           = 8,
   parameter int unsigned PIPEW         = 2,
   parameter bit          TWO_STAGE_REG = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   csb_i,
   input  logic [OPW-1:0]         byte_i,
   input  logic                   byte_valid_i,
   input  logic [1:0]             mode_i,
   input  logic                   busy_i,
   input  logic                   icpt_status_i,
   input  logic                   icpt_jedec_i,
   input  logic                   icpt_sfdp_i,
   input  logic [NSLOT-1:0]       slot_valid_i,
   input  logic [NSLOT*OPW-1:0]   slot_opcode_i,
   input  logic [NSLOT-1:0]       slot_rdcmd_i,
   input  logic [NSLOT-1:0]       slot_upload_i,
   input  logic [NSLOT*PIPEW-1:0] slot_pipe_i,
   output logic [ST_N-1:0]        state_o,
   output logic [DP_N-1:0]        dp_sel_o,
   output logic [OPW-1:0]         lat_opcode_o,
   output logic [PIPEW-1:0]       lat_pipe_o,
   output logic                   two_stage_o
);

   localparam int unsigned IDXW      = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int unsigned FIRST_GEN = NSTATUS + N_FIXED;

   if (NSTATUS < 1) begin : g_bad_status
      $error("NSTATUS must be at least 1");
   end
   if (NSLOT < FIRST_GEN) begin : g_bad_slots
      $error("NSLOT too small for the fixed slots");
   end
   if (PIPEW < 2) begin : g_bad_pipe
      $error("PIPEW must be at least 2");
   end

   logic [NSLOT-1:0] hit;
   logic [IDXW-1:0]  win_idx;
   logic             any_hit;
   logic             active;
   logic             pass;
   logic             decode;
   fcd_state_e       nxt_state;
   logic [DP_N-1:0]  nxt_dp;
   fcd_state_e       state_q;
   logic [DP_N-1:0]  dp_q;

   assign pass   = (mode_i == MODE_PASS);
   assign active = (mode_i == MODE_FLASH) || pass;
   assign decode = !csb_i && (state_q == ST_IDLE) && active && byte_valid_i;

   fcd_slot_match #(
      .NSLOT (NSLOT),
      .OPW   (OPW)
   ) u_match (
      .slot_valid_i  (slot_valid_i),
      .slot_opcode_i (slot_opcode_i),
      .byte_i        (byte_i),
      .hit_o         (hit),
      .win_idx_o     (win_idx)
   );

   fcd_classify #(
      .NSLOT   (NSLOT),
      .NSTATUS (NSTATUS)
   ) u_class (
      .hit_i         (hit),
      .win_rdcmd_i   (slot_rdcmd_i[win_idx]),
      .win_upload_i  (slot_upload_i[win_idx]),
      .pass_i        (pass),
      .busy_i        (busy_i),
      .icpt_status_i (icpt_status_i),
      .icpt_jedec_i  (icpt_jedec_i),
      .icpt_sfdp_i   (icpt_sfdp_i),
      .any_hit_o     (any_hit),
      .nxt_state_o   (nxt_state),
      .nxt_dp_o      (nxt_dp)
   );

   fcd_info_latch #(
      .OPW           (OPW),
      .PIPEW         (PIPEW),
      .TWO_STAGE_REG (TWO_STAGE_REG)
   ) u_info (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (decode && any_hit),
      .opcode_i    (slot_opcode_i[win_idx*OPW +: OPW]),
      .pipe_i      (slot_pipe_i[win_idx*PIPEW +: PIPEW]),
      .opcode_o    (lat_opcode_o),
      .pipe_o      (lat_pipe_o),
      .two_stage_o (two_stage_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         dp_q    <= '0;
      end else if (csb_i) begin
         state_q <= ST_IDLE;
         dp_q    <= '0;
      end else if (decode) begin
         state_q <= nxt_state;
         dp_q    <= nxt_dp;
      end
   end

   assign state_o  = state_q;
   assign dp_sel_o = dp_q;

   a_r13_state_onehot : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(state_q));

   a_r13_dp_onehot0 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(dp_q));

   a_r12_release_to_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      csb_i |=> (state_q == ST_IDLE) && (dp_q == '0));

   a_r3_inactive_stays_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == ST_IDLE) && !active) |=> (state_q == ST_IDLE));

   a_r3_handler_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!csb_i && (state_q != ST_IDLE)) |=> $stable(state_q) && $stable(dp_q));

   a_r8_busy_blocks_changes : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == ST_IDLE) && busy_i) |=>
         (state_q != ST_ADDR) && (state_q != ST_WRMODE) && !dp_q[DP_UPLOAD]);

   a_r13_idle_wait_no_dp : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == ST_IDLE) || (state_q == ST_WAIT)) |-> (dp_q == '0));

endmodule

// File: tb/flash_cmd_dispatch_tb_top.sv
module flash_cmd_dispatch_tb_top;

   localparam int NS  = 24;
   localparam int NST = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csb = 1'b1;
   logic [7:0]    byte_d = '0;
   logic          bval = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          busy = 1'b0;
   logic          ic_st = 1'b0, ic_jd = 1'b0, ic_sf = 1'b0;
   logic [NS-1:0]   s_valid, s_rd, s_up;
   logic [NS*8-1:0] s_op;
   logic [NS*2-1:0] s_pipe;
   logic [8:0]    st_o, dp_o;
   logic [7:0]    lop_o;
   logic [1:0]    lpipe_o;
   logic          ts_o;

   bit        tb_valid [NS];
   bit        tb_rd    [NS];
   bit        tb_up    [NS];
   logic [7:0] tb_op   [NS];
   logic [1:0] tb_pipe [NS];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] exp_lop   = '0;
   logic [1:0] exp_lpipe = '0;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NS; i++) begin
         s_valid[i]        = tb_valid[i];
         s_rd[i]           = tb_rd[i];
         s_up[i]           = tb_up[i];
         s_op[i*8 +: 8]    = tb_op[i];
         s_pipe[i*2 +: 2]  = tb_pipe[i];
      end
   end

   flash_cmd_dispatch dut_i (
      .clk_i (clk), .rst_ni (rst_n), .csb_i (csb), .byte_i (byte_d),
      .byte_valid_i (bval), .mode_i (mode), .busy_i (busy),
      .icpt_status_i (ic_st), .icpt_jedec_i (ic_jd), .icpt_sfdp_i (ic_sf),
      .slot_valid_i (s_valid), .slot_opcode_i (s_op), .slot_rdcmd_i (s_rd),
      .slot_upload_i (s_up), .slot_pipe_i (s_pipe),
      .state_o (st_o), .dp_sel_o (dp_o), .lat_opcode_o (lop_o),
      .lat_pipe_o (lpipe_o), .two_stage_o (ts_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected behaviour from the requirements
   task automatic model(input logic [7:0] b, input logic [1:0] md, input bit bsy,
                        input bit ist, input bit ijd, input bit isf,
                        output logic [8:0] est, output logic [8:0] edp,
                        output int win, output int nhits, output string tag);
      bit pass;
      win = -1; nhits = 0;
      for (int i = NS - 1; i >= 0; i--)
         if (tb_valid[i] && tb_op[i] == b) begin win = i; nhits++; end
      pass = (md == 2'd1);
      est = 9'h100; edp = 9'h000;
      if (md > 2'd1) begin est = 9'h001; tag = "R3"; win = -1; end
      else if (win < 0) tag = "R2";
      else if (win < NST) begin
         tag = pass ? "R6" : "R4";
         if (!pass || ist) begin est = 9'h002; edp = 9'h001; end
      end else if (win == NST) begin
         tag = pass ? "R6" : "R5";
         if (!pass || ijd) begin est = 9'h004; edp = 9'h002; end
      end else if (win == NST + 1) begin
         tag = pass ? "R6" : "R5";
         if (!pass || isf) begin est = 9'h008; edp = 9'h004; end
      end else if (tb_rd[win]) begin
         tag = "R9"; est = 9'h010; edp = 9'h008;
      end else if (tb_up[win]) begin
         tag = bsy ? "R8" : "R9";
         if (!bsy) begin est = 9'h020; edp = 9'h010; end
      end else if (win >= NST + 2 && win <= NST + 5) begin
         tag = bsy ? "R8" : "R7";
         if (!bsy) begin
            est = (win <= NST + 3) ? 9'h040 : 9'h080;
            edp = 9'h001 << (5 + win - (NST + 2));
         end
      end else tag = "R9";
      if (nhits > 1) tag = "R10";
   endtask

   task automatic txn(input logic [7:0] b, input logic [1:0] md, input bit bsy,
                      input bit ist, input bit ijd, input bit isf);
      logic [8:0] est, edp;
      int win, nh;
      string tag, ltag;
      model(b, md, bsy, ist, ijd, isf, est, edp, win, nh, tag);
      @(negedge clk);
      csb = 1'b0; mode = md; busy = bsy; ic_st = ist; ic_jd = ijd; ic_sf = isf; bval = 1'b0;
      @(negedge clk);
      byte_d = b; bval = 1'b1;
      @(negedge clk);
      bval = 1'b0;
      chk(tag, "state", 32'(st_o), 32'(est));
      chk(tag, "dp_sel", 32'(dp_o), 32'(edp));
      chk("R13", "state one-hot", 32'($onehot(st_o)), 32'd1);
      chk("R13", "dp at most one", 32'($countones(dp_o) <= 1), 32'd1);
      if (win >= 0) begin exp_lop = tb_op[win]; exp_lpipe = tb_pipe[win]; end
      // second byte must be ignored
      byte_d = tb_op[NST]; bval = 1'b1;
      @(negedge clk);
      bval = 1'b0;
      chk("R3", "state after 2nd byte", 32'(st_o), 32'(est));
      chk("R3", "dp after 2nd byte", 32'(dp_o), 32'(edp));
      ltag = (nh > 1) ? "R10" : "R11";
      chk(ltag, "lat_opcode", 32'(lop_o), 32'(exp_lop));
      chk(ltag, "lat_pipe", 32'(lpipe_o), 32'(exp_lpipe));
      chk("R11", "two_stage", 32'(ts_o), 32'(exp_lpipe >= 2'd2));
      // release with a byte shown while deselected
      csb = 1'b1; byte_d = tb_op[0]; bval = 1'b1; mode = 2'd0;
      @(negedge clk);
      bval = 1'b0;
      chk("R12", "state on release", 32'(st_o), 32'h001);
      chk("R12", "dp on release", 32'(dp_o), 32'h000);
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin
         tb_valid[i] = 1'b1;
         tb_op[i]    = 8'hA0 + 8'(i);
         tb_pipe[i]  = 2'(i % 4);
         tb_rd[i]    = (i >= 9 && i <= 13) || (i == 16);
         tb_up[i]    = (i >= 14 && i <= 18);
      end
      tb_valid[11] = 1'b0;          // invalid slot
      tb_op[20]    = tb_op[12];     // overlap, slot 12 must win
      tb_pipe[20]  = 2'd3;
      tb_pipe[12]  = 2'd1;
      repeat (3) @(negedge clk);
      chk("R1", "reset state", 32'(st_o), 32'h001);
      chk("R1", "reset dp", 32'(dp_o), 32'h000);
      chk("R1", "reset lat_opcode", 32'(lop_o), 32'h00);
      chk("R1", "reset lat_pipe", 32'(lpipe_o), 32'h0);
      chk("R1", "reset two_stage", 32'(ts_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k <= NS; k++) begin
         for (int md = 0; md < 4; md++) begin
            for (int bs = 0; bs < 2; bs++) begin
               for (int ic = 0; ic < 8; ic++) begin
                  txn((k == NS) ? 8'h00 : tb_op[k], 2'(md), bit'(bs),
                      ic[0], ic[1], ic[2]);
               end
            end
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule